// File: doc/BRIEF.md
# Multi-Lane Control-Stripping Frame Receiver

This block sits behind the symbol decoder and lane deskew of a multi-lane serial link. Every clock it takes one symbol from each of a fixed number of parallel lanes. A symbol is a byte together with a flag that says whether the byte is a control code or plain data. The block throws away every control code: link idles, clock-compensation fillers, padding and the two frame delimiters. It also discards data that falls outside a delimited frame. The data bytes that remain are packed, in lane order and then in arrival order, into full-width words on an AXI4-Stream master port.

The last word of each frame carries tlast, and its tkeep marks the valid bytes as a run of ones from byte 0 upward. The port has no back-pressure. The downstream consumer must accept one beat in every cycle where tvalid is high. The block holds back the most recent complete word until it learns whether more data follows. As a result, an end delimiter that arrives after the frame's final full word still lands tlast on that word.

A frame may start only in lane 0. This keeps the number of words produced in any stretch of cycles no larger than the number of cycles, so a small internal word queue never fills.

Top module: `lane_frame_rx`

## Requirements
- R1: A symbol with its control flag set is never forwarded as data, whatever its code: idle 0xBC, clock compensation 0xF7, padding 0x9C, start 0x5C, end 0xFD and unknown codes. A byte with its control flag clear is data even when its value equals one of these codes.
- R2: A frame opens only when lane 0 carries a start code (control flag set, 0x5C) while no frame is open. A start code in lanes 1 and up, or in any lane while a frame is open, has no effect.
- R3: Data bytes of a frame are emitted in order: within a cycle from lane 0 upward, and across cycles oldest first. Lane i is `lane_data[8i+7:8i]`, and beat byte j is `m_tdata[8j+7:8j]`, with the earliest byte in byte 0.
- R4: Data bytes that are outside a frame are discarded. This covers bytes in cycles where no frame is open and bytes after an end code in the same cycle.
- R5: An end code (control flag set, 0xFD) closes the open frame, and the frame's final beat carries tlast.
- R6: On a beat without tlast, tkeep is all ones. On a final beat, tkeep has its lowest n bits set, where n is the count of that beat's valid bytes (1 to LANES). Unused bytes read as zero.
- R7: If a frame's length is a multiple of LANES and its end code arrives in a later cycle than its last data byte, tlast is still placed on the last full word and no extra beat appears.
- R8: A frame with no data bytes produces no beat.
- R9: While reset is high and in the first cycle after it, tvalid is low.
- R10: Each rebuilt word is presented for exactly one cycle, in order, and the internal word queue never holds more than QDEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | LANES*8 | Received byte per lane, lane i in bits 8i+7:8i |
| lane_ctl | input | LANES | Control flag per lane, high marks a control code |
| m_tdata | output | LANES*8 | Rebuilt data word |
| m_tvalid | output | 1 | Beat valid, one cycle per word |
| m_tlast | output | 1 | Final beat of a frame |
| m_tkeep | output | LANES | Valid-byte mask of the beat |

## Verification
The bound checker enforces the tkeep shape on every beat: all ones when tlast is low, and a contiguous low run otherwise. It also checks that the word queue stays within its depth and that tvalid is quiet after reset. Byte order, the discarding of controls and of out-of-frame data, and the placement of tlast on a held-back word can only be shown by the bench. The bench sweeps frame lengths against patterns of interleaved fillers, late end codes and stray bytes, and compares every beat with words it computes from the frame contents.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    localparam int SYM_W = 8;

    localparam logic [SYM_W-1:0] K_IDLE = 8'hBC;
    localparam logic [SYM_W-1:0] K_SOF  = 8'h5C;
    localparam logic [SYM_W-1:0] K_EOF  = 8'hFD;
    localparam logic [SYM_W-1:0] K_PAD  = 8'h9C;
    localparam logic [SYM_W-1:0] K_CC   = 8'hF7;

    typedef enum logic [1:0] {
        SYM_DATA,
        SYM_SOF,
        SYM_EOF,
        SYM_DROP
    } sym_kind_e;

    // Classify one lane symbol; every control code other than the two
    // delimiters is simply dropped (R1).
    function automatic sym_kind_e sym_class(input logic [SYM_W-1:0] b, input logic k);
        if (!k) return SYM_DATA;
        case (b)
            K_SOF:                return SYM_SOF;
            K_EOF:                return SYM_EOF;
            K_IDLE, K_PAD, K_CC:  return SYM_DROP;
            default:              return SYM_DROP;
        endcase
    endfunction

endpackage

// File: rtl/lfr_lane_filter.sv
module lfr_lane_filter
    import lfr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*SYM_W-1:0] lane_data,
    input  logic [LANES-1:0]       lane_ctl,
    output logic [LANES-1:0]       dmask,
    output logic                   frame_end
);

    logic      in_frame;
    logic      opened;
    logic      alive;
    sym_kind_e kind;

    always_comb begin
        opened    = in_frame | (sym_class(lane_data[SYM_W-1:0], lane_ctl[0]) == SYM_SOF);
        alive     = opened;
        frame_end = 1'b0;
        dmask     = '0;
        kind      = SYM_DROP;
        for (int i = 0; i < LANES; i++) begin
            kind = sym_class(lane_data[i*SYM_W +: SYM_W], lane_ctl[i]);
            if (alive && kind == SYM_DATA) dmask[i] = 1'b1;
            if (alive && kind == SYM_EOF) begin
                frame_end = 1'b1;
                alive     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) in_frame <= 1'b0;
        else     in_frame <= opened & ~frame_end;
    end

endmodule

// File: rtl/lfr_packer.sv
module lfr_packer
    import lfr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*SYM_W-1:0] lane_data,
    input  logic [LANES-1:0]       dmask,
    input  logic                   frame_end,
    output logic                   w0_vld,
    output logic                   w0_last,
    output logic [LANES*SYM_W-1:0] w0_data,
    output logic                   w1_vld,
    output logic [LANES*SYM_W-1:0] w1_data,
    output logic [LANES-1:0]       w1_keep,
    output logic                   mark_tail
);

    localparam int IW = $clog2(2*LANES);
    localparam int CW = IW + 1;

    logic [LANES-1:0][SYM_W-1:0]   acc;
    logic [CW-1:0]                 pcnt;
    logic [2*LANES-1:0][SYM_W-1:0] cat;
    logic [LANES-1:0][SYM_W-1:0]   rem_bytes;
    logic [LANES-1:0][SYM_W-1:0]   tail_bytes;
    logic [CW-1:0]                 pos;
    logic [CW-1:0]                 rem;
    logic                          full;

    // Append this cycle's in-frame bytes behind the carried partial word.
    always_comb begin
        cat = '0;
        for (int j = 0; j < LANES; j++) cat[j] = acc[j];
        pos = pcnt;
        for (int i = 0; i < LANES; i++) begin
            if (dmask[i]) begin
                cat[pos[IW-1:0]] = lane_data[i*SYM_W +: SYM_W];
                pos = pos + CW'(1);
            end
        end
        full      = (pos >= CW'(LANES));
        rem       = full ? pos - CW'(LANES) : pos;
        rem_bytes = full ? cat[2*LANES-1:LANES] : cat[LANES-1:0];
        for (int j = 0; j < LANES; j++) begin
            w1_keep[j]    = (CW'(j) < rem);
            tail_bytes[j] = w1_keep[j] ? rem_bytes[j] : '0;
        end
    end

    assign w0_vld    = full;
    assign w0_data   = cat[LANES-1:0];
    assign w0_last   = frame_end && full && (rem == '0);
    assign w1_vld    = frame_end && (rem != '0);
    assign w1_data   = tail_bytes;
    assign mark_tail = frame_end && !full && (rem == '0);

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            pcnt <= '0;
            acc  <= '0;
        end else begin
            pcnt <= rem;
            acc  <= rem_bytes;
        end
    end

endmodule

// File: rtl/lfr_word_queue.sv
module lfr_word_queue
    import lfr_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push0,
    input  logic                   last0,
    input  logic [LANES*SYM_W-1:0] d0,
    input  logic                   push1,
    input  logic [LANES*SYM_W-1:0] d1,
    input  logic [LANES-1:0]       k1,
    input  logic                   mark_tail,
    output logic [LANES*SYM_W-1:0] m_tdata,
    output logic                   m_tvalid,
    output logic                   m_tlast,
    output logic [LANES-1:0]       m_tkeep,
    output logic [$clog2(DEPTH):0] fill
);

    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [LANES*SYM_W-1:0] data;
        logic [LANES-1:0]       keep;
        logic                   last;
    } beat_t;

    beat_t         mem [DEPTH];
    logic [PW-1:0] rd;
    logic [PW-1:0] wr;
    logic [PW-1:0] wr2;
    logic [PW-1:0] tail;
    logic [PW:0]   cnt;
    logic          pop;

    // The newest word waits until a successor or the end code decides its tlast.
    always_comb begin
        pop  = (cnt > (PW+1)'(1)) || ((cnt != '0) && mem[rd].last);
        wr   = rd + cnt[PW-1:0];
        wr2  = wr + PW'(push0);
        tail = wr - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd  <= '0;
            cnt <= '0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            if (mark_tail && cnt != '0) mem[tail].last <= 1'b1;
            if (push0) mem[wr]  <= {d0, {LANES{1'b1}}, last0};
            if (push1) mem[wr2] <= {d1, k1, 1'b1};
            rd  <= rd + PW'(pop);
            cnt <= cnt + (PW+1)'(push0) + (PW+1)'(push1) - (PW+1)'(pop);
        end
    end

    assign m_tvalid = pop;
    assign m_tdata  = mem[rd].data;
    assign m_tkeep  = mem[rd].keep;
    assign m_tlast  = mem[rd].last;
    assign fill     = cnt;

endmodule

// File: rtl/lane_frame_rx.sv
module lane_frame_rx
    import lfr_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int QDEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*SYM_W-1:0] lane_data,
    input  logic [LANES-1:0]       lane_ctl,
    output logic [LANES*SYM_W-1:0] m_tdata,
    output logic                   m_tvalid,
    output logic                   m_tlast,
    output logic [LANES-1:0]       m_tkeep
);

    logic [LANES-1:0]        dmask;
    logic                    frame_end;
    logic                    w0_vld;
    logic                    w0_last;
    logic [LANES*SYM_W-1:0]  w0_data;
    logic                    w1_vld;
    logic [LANES*SYM_W-1:0]  w1_data;
    logic [LANES-1:0]        w1_keep;
    logic                    mark_tail;
    logic [$clog2(QDEPTH):0] q_fill;

    lfr_lane_filter #(.LANES(LANES)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .lane_data (lane_data),
        .lane_ctl  (lane_ctl),
        .dmask     (dmask),
        .frame_end (frame_end)
    );

    lfr_packer #(.LANES(LANES)) u_packer (
        .clk       (clk),
        .rst       (rst),
        .lane_data (lane_data),
        .dmask     (dmask),
        .frame_end (frame_end),
        .w0_vld    (w0_vld),
        .w0_last   (w0_last),
        .w0_data   (w0_data),
        .w1_vld    (w1_vld),
        .w1_data   (w1_data),
        .w1_keep   (w1_keep),
        .mark_tail (mark_tail)
    );

    lfr_word_queue #(.LANES(LANES), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push0     (w0_vld),
        .last0     (w0_last),
        .d0        (w0_data),
        .push1     (w1_vld),
        .d1        (w1_data),
        .k1        (w1_keep),
        .mark_tail (mark_tail),
        .m_tdata   (m_tdata),
        .m_tvalid  (m_tvalid),
        .m_tlast   (m_tlast),
        .m_tkeep   (m_tkeep),
        .fill      (q_fill)
    );

endmodule

// File: rtl/lane_frame_rx_chk.sv
module lane_frame_rx_chk #(
    parameter int LANES  = 4,
    parameter int QDEPTH = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    m_tvalid,
    input logic                    m_tlast,
    input logic [LANES-1:0]        m_tkeep,
    input logic [$clog2(QDEPTH):0] q_fill
);

    // R6: middle beats are full width
    p_keep_full_r6: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tlast) |-> (m_tkeep == {LANES{1'b1}}));

    // R6: every beat's mask is a nonempty run of ones from byte 0
    p_keep_run_r6: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tkeep[0] && ((LANES'(m_tkeep + 1'b1) & m_tkeep) == '0)));

    // R10: queue stays within its depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        q_fill <= ($clog2(QDEPTH)+1)'(QDEPTH));

    // R9: nothing is presented in the cycle after reset
    p_quiet_after_reset_r9: assert property (@(posedge clk)
        rst |=> !m_tvalid);

endmodule

bind lane_frame_rx lane_frame_rx_chk #(.LANES(LANES), .QDEPTH(QDEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .m_tvalid (m_tvalid),
    .m_tlast  (m_tlast),
    .m_tkeep  (m_tkeep),
    .q_fill   (q_fill)
);

// File: tb/test_lane_frame_rx.sv
module test_lane_frame_rx;
    import lfr_pkg::*;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N*8-1:0] lane_data = {N{K_IDLE}};
    logic [N-1:0]   lane_ctl  = '1;
    logic [N*8-1:0] m_tdata;
    logic           m_tvalid;
    logic           m_tlast;
    logic [N-1:0]   m_tkeep;

    always #4 clk = ~clk;

    lane_frame_rx #(.LANES(N), .QDEPTH(4)) i_lane_frame_rx (
        .clk (clk), .rst (rst), .lane_data (lane_data), .lane_ctl (lane_ctl),
        .m_tdata (m_tdata), .m_tvalid (m_tvalid), .m_tlast (m_tlast), .m_tkeep (m_tkeep)
    );

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    int exp_n  = 0;
    logic [N*8-1:0] exp_d [0:1023];
    logic [N-1:0]   exp_k [0:1023];
    logic           exp_l [0:1023];
    logic           exp_m [0:1023];

    logic [N*8-1:0] cur_d;
    logic [N-1:0]   cur_c;
    int             li = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Beat monitor: outputs come from registers only, so negedge sampling is stable.
    always @(negedge clk) begin
        if (!rst && m_tvalid) begin
            if (seen >= exp_n) begin
                chk(1'b0, "R4/R10 unexpected beat", 64'(m_tdata), 64'(0));
            end else begin
                logic [N*8-1:0] msk;
                for (int j = 0; j < N; j++) msk[j*8 +: 8] = {8{m_tkeep[j]}};
                chk((m_tdata & msk) == exp_d[seen], "R1/R3 data", 64'(m_tdata & msk), 64'(exp_d[seen]));
                chk(m_tkeep == exp_k[seen], "R6 keep", 64'(m_tkeep), 64'(exp_k[seen]));
                chk(m_tlast == exp_l[seen], exp_m[seen] ? "R7 last" : "R5 last",
                    64'(m_tlast), 64'(exp_l[seen]));
            end
            seen++;
        end
    end

    task automatic put(input logic [7:0] b, input logic c);
        cur_d[li*8 +: 8] = b;
        cur_c[li]        = c;
        li++;
        if (li == N) begin
            @(negedge clk);
            lane_data = cur_d;
            lane_ctl  = cur_c;
            li = 0;
        end
    endtask

    task automatic align(input logic [7:0] b);
        while (li != 0) put(b, 1'b1);
    endtask

    task automatic idle_cycles(input int n);
        align(K_IDLE);
        repeat (n * N) put(K_IDLE, 1'b1);
    endtask

    function automatic logic [7:0] fbyte(input int len, input int v, input int i);
        if (i == 1) return K_IDLE;   // data that looks like a code (R1)
        if (i == 2) return K_EOF;
        return 8'(len * 29 + i * 53 + v * 11 + 1);
    endfunction

    // v bit 0: stray data after the end code; bit 1: padding before the end code;
    // bit 2: control fillers between data bytes.
    task automatic frame(input int len, input int v);
        int nw;
        nw = (len + N - 1) / N;
        for (int wi = 0; wi < nw; wi++) begin
            logic [N*8-1:0] w;
            int nb;
            w  = '0;
            nb = (len - wi * N > N) ? N : len - wi * N;
            for (int j = 0; j < nb; j++) w[j*8 +: 8] = fbyte(len, v, wi * N + j);
            exp_d[exp_n] = w;
            exp_k[exp_n] = N'((1 << nb) - 1);
            exp_l[exp_n] = (wi == nw - 1);
            exp_m[exp_n] = (len % N == 0);
            exp_n++;
        end
        align(K_IDLE);
        put(K_SOF, 1'b1);
        for (int i = 0; i < len; i++) begin
            put(fbyte(len, v, i), 1'b0);
            if ((v & 4) != 0 && (i % 3) == 1) begin
                case (i % 4)
                    0:       put(K_PAD, 1'b1);
                    1:       put(K_IDLE, 1'b1);
                    2:       put(K_CC, 1'b1);
                    default: put(K_SOF, 1'b1);
                endcase
            end
        end
        if ((v & 2) != 0) repeat (N) put(K_PAD, 1'b1);
        put(K_EOF, 1'b1);
        if ((v & 1) != 0) put(8'h6B, 1'b0);
        align(K_PAD);
    endtask

    // Junk between frames: start code outside lane 0, data, a lone end code.
    task automatic junk();
        align(K_IDLE);
        put(8'h11, 1'b0); put(K_SOF, 1'b1); put(8'h22, 1'b0); put(8'h33, 1'b0);
        put(8'h44, 1'b0); put(K_EOF, 1'b1); put(K_CC, 1'b1); put(K_IDLE, 1'b1);
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(m_tvalid == 1'b0, "R9 tvalid in reset", 64'(m_tvalid), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R9 tvalid after reset", 64'(m_tvalid), 64'(0));

        // Sweep: lengths 0..12 against all eight stimulus variants.
        for (int v = 0; v < 8; v++) begin
            for (int len = 0; len <= 12; len++) begin
                frame(len, v);
                if ((len % 5) == 2) junk();
            end
        end
        idle_cycles(12);
        chk(seen == exp_n, "R4/R10 beat count after sweep", 64'(seen), 64'(exp_n));

        // R2: start codes outside lane 0 never open a frame.
        base = seen;
        repeat (3) junk();
        idle_cycles(8);
        chk(seen == base, "R2 misplaced start ignored", 64'(seen), 64'(base));

        // R8: empty frames produce nothing.
        base = seen;
        for (int v = 0; v < 4; v++) frame(0, v);
        idle_cycles(8);
        chk(seen == base, "R8 empty frame beats", 64'(seen), 64'(base));

        // Recovery after junk and empty frames.
        frame(5, 1);
        frame(8, 2);
        idle_cycles(10);
        chk(seen == exp_n, "R5 beat count at end", 64'(seen), 64'(exp_n));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d beats", seen, exp_n);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule